// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the serial-side front end of a page-organised flash model. It watches a four-wire SPI slave port, collects a one-byte opcode and a three-byte address, sorts the opcode into a small set of command classes, and splits the address into a page number and a byte offset. Two page layouts are supported, chosen by a static input: 264 bytes per page or 256 bytes per page. When the address phase has been collected, plus a dummy byte for the fast read opcodes, the block raises a one-cycle strobe toward the back end. For read commands it then shifts out bytes that the back end supplies for the address it presents. It advances that address after every byte.

All SPI pins are oversampled in the system clock domain through a short synchroniser. Each chip-select assertion records the idle level of SCK, which tells SPI mode 0 from mode 3. The serial output enable is raised only during the data phase of a read and only while chip select is held low. The flash array, the erase and program timing, and sector protection all live in the back end.

The controller states are IDLE (deselected or waiting for a select edge), OPCODE (8 bits in), ADDR (24 bits in), DUMMY (8 bits in), DATA (bytes out) and SINK (ignore the rest of the frame). The transitions are: IDLE to OPCODE on a chip-select fall. OPCODE to ADDR on a known opcode, or to SINK on an unknown one. ADDR to DUMMY for a fast read, to DATA for a plain read, or to SINK for an erase or program. DUMMY to DATA. Any state returns to IDLE while chip select is high.

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: After reset, miso_oe_o=0, cmd_valid_o=0 and mode3_o=1. A frame produces no strobe and no output unless a chip-select falling edge has been seen since reset, so a select held low through reset is ignored.
- R2: At every chip-select falling edge, mode3_o takes the SCK level at that moment (1 = mode 3, 0 = mode 0). It holds that value until the next falling edge.
- R3: Input bits are taken on SCK rising edges and output bits change on SCK falling edges, most significant bit first in both directions.
- R4: With std_page_i=1 (264-byte pages), address bits 23..19 are ignored, page_o = address bits 18..9 and byte_o = address bits 8..0.
- R5: With std_page_i=0 (256-byte pages), address bits 23..18 are ignored, page_o = address bits 17..8 and byte_o = {0, address bits 7..0}.
- R6: The opcode classes on cmd_class_o are: 0x0B array read with one dummy byte (class 1), 0x03 array read (class 1), 0xD4 buffer read with one dummy byte (class 2), 0xD1 buffer read (class 2), 0x81 page erase (class 3), 0x82 page program (class 4). The strobe follows the last address bit, or the last dummy bit when a dummy byte is needed.
- R7: cmd_valid_o lasts exactly one clock per frame, and cmd_class_o, page_o and byte_o are valid in that cycle.
- R8: For a read, miso_oe_o rises in the strobe cycle. The first byte shifted out is rd_data_i as seen on the first SCK falling edge after the strobe, while page_o/byte_o still show the decoded address.
- R9: During an array read, the address advances by one after each byte. Past the last byte of a page (263 or 255) it moves to byte 0 of the next page, and past the last byte of page 1023 it moves to page 0 byte 0, with no gap.
- R10: During a buffer read, byte_o wraps from the last byte of the page to 0 and page_o does not change.
- R11: Raising chip select ends any frame. miso_oe_o is low within the synchroniser delay, and a frame cut short before its strobe produces no strobe. The next frame decodes normally.
- R12: An unknown opcode produces no strobe, and miso_oe_o stays 0 until chip select rises.
- R13: Erase and program opcodes produce a strobe with their fields but never assert miso_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | SPI serial clock |
| cs_n_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data in |
| std_page_i | input | 1 | 1 = 264-byte pages, 0 = 256-byte pages |
| rd_data_i | input | 8 | Back-end byte for the address on page_o/byte_o |
| miso_o | output | 1 | Serial data out, meaningful only while miso_oe_o=1 |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| mode3_o | output | 1 | SPI mode recorded at the last select edge |
| cmd_valid_o | output | 1 | One-cycle decoded command strobe |
| cmd_class_o | output | 3 | Command class (see R6) |
| page_o | output | 10 | Page field, then the live read page |
| byte_o | output | 9 | Byte field, then the live read byte |

## Verification
A bad state in the controller shows up within one byte time as a missing strobe, a doubled strobe, or an early output enable. A bit counter that is off by one shifts every decoded field and every data bit, so it is caught on the first frame. An address-advance fault only shows at the ports once the data crosses a page end or the array end, so the read runs are placed to start a few bytes before those boundaries. Mode capture is checked right after each select edge and again while idle, because a wrong value only persists until the next select.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [2:0] {
        OPC_NONE       = 3'd0,
        OPC_ARRAY_RD   = 3'd1,
        OPC_BUF_RD     = 3'd2,
        OPC_PAGE_ERASE = 3'd3,
        OPC_PAGE_PROG  = 3'd4
    } op_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_SINK
    } fe_state_e;

    typedef struct packed {
        op_class_e cls;
        logic      dummy;
    } op_info_t;

    function automatic op_info_t decode_opcode(input logic [7:0] code);
        op_info_t r;
        r.cls   = OPC_NONE;
        r.dummy = 1'b0;
        case (code)
            8'h0B: begin r.cls = OPC_ARRAY_RD;   r.dummy = 1'b1; end
            8'h03: begin r.cls = OPC_ARRAY_RD;   r.dummy = 1'b0; end
            8'hD4: begin r.cls = OPC_BUF_RD;     r.dummy = 1'b1; end
            8'hD1: begin r.cls = OPC_BUF_RD;     r.dummy = 1'b0; end
            8'h81: begin r.cls = OPC_PAGE_ERASE; r.dummy = 1'b0; end
            8'h82: begin r.cls = OPC_PAGE_PROG;  r.dummy = 1'b0; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic class_is_read(input op_class_e c);
        return (c == OPC_ARRAY_RD) || (c == OPC_BUF_RD);
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
// Oversamples the SPI pins and produces edge pulses in the clk domain.
module spi_fe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic sck_lvl,
    output logic cs_fall,
    output logic cs_n_lvl,
    output logic mosi_lvl
);
    // Reset value {sck, cs_n, mosi}: clock idle high, select seen as
    // asserted so a select held low through reset yields no falling edge.
    localparam logic [2:0] RST_VAL = 3'b100;

    logic [2:0] chain [STAGES];
    logic       sck_prev;
    logic       cs_prev;
    logic [2:0] last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            sck_prev <= 1'b1;
            cs_prev  <= 1'b0;
        end else begin
            chain[0] <= {sck_i, cs_n_i, mosi_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_prev <= last[2];
            cs_prev  <= last[1];
        end
    end

    assign last     = chain[STAGES-1];
    assign sck_lvl  = last[2];
    assign sck_rise = last[2] & ~sck_prev;
    assign sck_fall = ~last[2] & sck_prev;
    assign cs_n_lvl = last[1];
    assign cs_fall  = ~last[1] & cs_prev;
    assign mosi_lvl = last[0];

endmodule

// File: rtl/spi_fe_addr_split.sv
// Splits the 24-bit serial address into page and byte fields.
module spi_fe_addr_split #(
    parameter int PAGE_W     = 10,
    parameter int STD_BYTE_W = 9,
    parameter int BIN_BYTE_W = 8,
    parameter int ADDR_W     = 24
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  std_mode,
    output logic [PAGE_W-1:0]     page,
    output logic [STD_BYTE_W-1:0] byte_idx
);
    localparam int STD_TOP = STD_BYTE_W + PAGE_W - 1;
    localparam int BIN_TOP = BIN_BYTE_W + PAGE_W - 1;
    localparam int PAD     = STD_BYTE_W - BIN_BYTE_W;

    logic unused_addr_bits;
    assign unused_addr_bits = ^addr[ADDR_W-1:STD_TOP+1];

    always_comb begin
        if (std_mode) begin
            page     = addr[STD_TOP:STD_BYTE_W];
            byte_idx = addr[STD_BYTE_W-1:0];
        end else begin
            page     = addr[BIN_TOP:BIN_BYTE_W];
            byte_idx = {{PAD{1'b0}}, addr[BIN_BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend
    import spi_fe_pkg::*;
#(
    parameter int PAGE_W      = 10,
    parameter int STD_PAGE    = 264,
    parameter int BIN_PAGE    = 256,
    parameter int ADDR_BYTES  = 3,
    parameter int DUMMY_BYTES = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sck_i,
    input  logic                          cs_n_i,
    input  logic                          mosi_i,
    input  logic                          std_page_i,
    input  logic [7:0]                    rd_data_i,
    output logic                          miso_o,
    output logic                          miso_oe_o,
    output logic                          mode3_o,
    output logic                          cmd_valid_o,
    output logic [2:0]                    cmd_class_o,
    output logic [PAGE_W-1:0]             page_o,
    output logic [$clog2(STD_PAGE)-1:0]   byte_o
);
    localparam int STD_BYTE_W = $clog2(STD_PAGE);
    localparam int BIN_BYTE_W = $clog2(BIN_PAGE);
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int DUMMY_W    = 8 * DUMMY_BYTES;
    localparam int CNT_MAX    = (ADDR_W > DUMMY_W) ? ADDR_W : DUMMY_W;
    localparam int CNT_W      = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_W - 1);
    localparam logic [STD_BYTE_W-1:0] STD_LAST = STD_BYTE_W'(STD_PAGE - 1);
    localparam logic [STD_BYTE_W-1:0] BIN_LAST = STD_BYTE_W'(BIN_PAGE - 1);

    logic sck_rise, sck_fall, sck_lvl, cs_fall, cs_n_lvl, mosi_lvl;

    spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .cs_n_i   (cs_n_i),
        .mosi_i   (mosi_i),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sck_lvl  (sck_lvl),
        .cs_fall  (cs_fall),
        .cs_n_lvl (cs_n_lvl),
        .mosi_lvl (mosi_lvl)
    );

    fe_state_e                state, state_nx;
    logic [CNT_W-1:0]         bit_cnt;
    logic [ADDR_W-2:0]        in_sh;
    logic [ADDR_W-1:0]        in_next;
    op_info_t                 op_q, op_new;
    logic [PAGE_W-1:0]        page_q, page_nx, split_page;
    logic [STD_BYTE_W-1:0]    byte_q, byte_nx, split_byte, byte_last;
    logic                     byte_wrap;
    logic                     strobe_q;
    logic                     mode3_q;
    logic [7:0]               out_sh;
    logic [2:0]               out_cnt;
    logic                     last_op_bit, last_addr_bit, last_dummy_bit;

    assign in_next = {in_sh, mosi_lvl};
    assign op_new  = decode_opcode(in_next[7:0]);

    spi_fe_addr_split #(
        .PAGE_W     (PAGE_W),
        .STD_BYTE_W (STD_BYTE_W),
        .BIN_BYTE_W (BIN_BYTE_W),
        .ADDR_W     (ADDR_W)
    ) u_split (
        .addr     (in_next),
        .std_mode (std_page_i),
        .page     (split_page),
        .byte_idx (split_byte)
    );

    assign last_op_bit    = (state == ST_OPCODE) && sck_rise && (bit_cnt == OP_LAST);
    assign last_addr_bit  = (state == ST_ADDR)   && sck_rise && (bit_cnt == ADDR_LAST);
    assign last_dummy_bit = (state == ST_DUMMY)  && sck_rise && (bit_cnt == DUMMY_LAST);

    // Read address advance: page carry only for array reads.
    assign byte_last = std_page_i ? STD_LAST : BIN_LAST;
    assign byte_wrap = (byte_q >= byte_last);
    assign byte_nx   = byte_wrap ? '0 : byte_q + 1'b1;
    assign page_nx   = (op_q.cls == OPC_ARRAY_RD && byte_wrap) ? page_q + 1'b1 : page_q;

    always_comb begin
        state_nx = state;
        if (cs_n_lvl) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) state_nx = ST_OPCODE;
                ST_OPCODE: if (last_op_bit)
                               state_nx = (op_new.cls == OPC_NONE) ? ST_SINK : ST_ADDR;
                ST_ADDR:   if (last_addr_bit)
                               state_nx = op_q.dummy ? ST_DUMMY
                                        : (class_is_read(op_q.cls) ? ST_DATA : ST_SINK);
                ST_DUMMY:  if (last_dummy_bit) state_nx = ST_DATA;
                ST_DATA:   state_nx = ST_DATA;
                ST_SINK:   state_nx = ST_SINK;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            in_sh    <= '0;
            op_q     <= '{cls: OPC_NONE, dummy: 1'b0};
            page_q   <= '0;
            byte_q   <= '0;
            strobe_q <= 1'b0;
            mode3_q  <= 1'b1;
            out_sh   <= '0;
            out_cnt  <= '0;
        end else begin
            strobe_q <= 1'b0;
            if (cs_fall) begin
                mode3_q <= sck_lvl;
                bit_cnt <= '0;
                out_sh  <= '0;
                out_cnt <= '0;
            end else if (!cs_n_lvl) begin
                case (state)
                    ST_OPCODE: if (sck_rise) begin
                        in_sh <= in_next[ADDR_W-2:0];
                        if (bit_cnt == OP_LAST) begin
                            bit_cnt <= '0;
                            op_q    <= op_new;
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_ADDR: if (sck_rise) begin
                        in_sh <= in_next[ADDR_W-2:0];
                        if (bit_cnt == ADDR_LAST) begin
                            bit_cnt  <= '0;
                            page_q   <= split_page;
                            byte_q   <= split_byte;
                            strobe_q <= ~op_q.dummy;
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_DUMMY: if (sck_rise) begin
                        if (bit_cnt == DUMMY_LAST) begin
                            bit_cnt  <= '0;
                            strobe_q <= 1'b1;
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_DATA: if (sck_fall) begin
                        out_sh  <= (out_cnt == 3'd0) ? rd_data_i : {out_sh[6:0], 1'b0};
                        out_cnt <= out_cnt + 1'b1;
                        if (out_cnt == 3'd7) begin
                            byte_q <= byte_nx;
                            page_q <= page_nx;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso_oe_o   = (state == ST_DATA);
    assign miso_o      = miso_oe_o & out_sh[7];
    assign mode3_o     = mode3_q;
    assign cmd_valid_o = strobe_q;
    assign cmd_class_o = op_q.cls;
    assign page_o      = page_q;
    assign byte_o      = byte_q;

    AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_lvl |=> !miso_oe_o); // R11

    AST_NO_STROBE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_lvl |=> !cmd_valid_o); // R11

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(mode3_o)); // R2

    AST_OE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe_o) |-> cmd_valid_o); // R8

endmodule

// File: tb/spi_flash_cmd_frontend_tb.sv
module spi_flash_cmd_frontend_tb;

    localparam int H = 6; // clk cycles per SCK half period

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic        p264;
        logic        m3;
        logic        dmy;
        logic [2:0]  cls;
        logic [9:0]  pg;
        logic [8:0]  by;
        logic [2:0]  nrd;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h0B, 24'hF80A0A, 1'b1, 1'b1, 1'b1, 3'd1, 10'd5,     9'd10,  3'd3},
        '{8'h03, 24'hFD2345, 1'b0, 1'b0, 1'b0, 3'd1, 10'h123,   9'h045, 3'd2},
        '{8'hD4, 24'h000105, 1'b1, 1'b0, 1'b1, 3'd2, 10'd0,     9'd261, 3'd4},
        '{8'hD1, 24'h0000FE, 1'b0, 1'b1, 1'b0, 3'd2, 10'd0,     9'h0FE, 3'd3},
        '{8'h81, 24'h07FE00, 1'b1, 1'b1, 1'b0, 3'd3, 10'h3FF,   9'd0,   3'd0},
        '{8'h82, 24'h03FF80, 1'b0, 1'b0, 1'b0, 3'd4, 10'h3FF,   9'h080, 3'd0},
        '{8'h0B, 24'h07FF06, 1'b1, 1'b0, 1'b1, 3'd1, 10'h3FF,   9'd262, 3'd3},
        '{8'h03, 24'h03FFFF, 1'b0, 1'b1, 1'b0, 3'd1, 10'h3FF,   9'h0FF, 3'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_i = 1'b1;
    logic       cs_n_i = 1'b0;
    logic       mosi_i = 1'b0;
    logic       std_page_i = 1'b1;
    logic [7:0] rd_data_i;
    logic       miso_o, miso_oe_o, mode3_o, cmd_valid_o;
    logic [2:0] cmd_class_o;
    logic [9:0] page_o;
    logic [8:0] byte_o;

    int checks = 0;
    int fails  = 0;
    int strb_n = 0;
    int oe_n   = 0;
    logic [2:0] cap_cls  = '0;
    logic [9:0] cap_page = '0;
    logic [8:0] cap_byte = '0;
    logic [7:0] rx_mem [8];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] bdata(input logic [9:0] pg, input logic [8:0] by);
        return by[7:0] ^ {pg[3:0], pg[7:4]} ^ {7'd0, by[8]} ^ {6'd0, pg[9:8]};
    endfunction

    assign rd_data_i = bdata(page_o, byte_o);

    spi_flash_cmd_frontend u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck_i),
        .cs_n_i      (cs_n_i),
        .mosi_i      (mosi_i),
        .std_page_i  (std_page_i),
        .rd_data_i   (rd_data_i),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o),
        .mode3_o     (mode3_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_class_o (cmd_class_o),
        .page_o      (page_o),
        .byte_o      (byte_o)
    );

    always @(posedge clk) begin
        if (cmd_valid_o) begin
            strb_n   <= strb_n + 1;
            cap_cls  <= cmd_class_o;
            cap_page <= page_o;
            cap_byte <= byte_o;
        end
        if (miso_oe_o) oe_n <= oe_n + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck_i  = 1'b0;
            mosi_i = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso_o;
            sck_i = 1'b1;
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic sel(input logic m3);
        sck_i = m3;
        repeat (4) @(negedge clk);
        cs_n_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic desel(input logic m3);
        if (!m3) sck_i = 1'b0;
        repeat (H) @(negedge clk);
        cs_n_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic advance(inout logic [9:0] pg, inout logic [8:0] by,
                           input logic p264, input logic arr);
        logic [8:0] lastb;
        lastb = p264 ? 9'd263 : 9'd255;
        if (by >= lastb) begin
            by = '0;
            if (arr) pg = pg + 1'b1;
        end else by = by + 1'b1;
    endtask

    initial begin
        logic [7:0] rx;
        logic [9:0] epg;
        logic [8:0] eby;
        int s0, o0;

        // Reset with select already low: must be ignored.
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 oe after reset", miso_oe_o, 0);
        chk("R1 mode after reset", mode3_o, 1);
        chk("R1 strobe after reset", cmd_valid_o, 0);
        xfer(8'h0B, rx); xfer(8'h00, rx); xfer(8'h01, rx); xfer(8'h02, rx);
        xfer(8'h00, rx); xfer(8'h00, rx);
        chk("R1 no strobe without select edge", strb_n, 0);
        chk("R1 no output without select edge", oe_n, 0);
        cs_n_i = 1'b1;
        repeat (8) @(negedge clk);

        // Table-driven frames.
        for (int v = 0; v < NVEC; v++) begin
            std_page_i = VECS[v].p264;
            s0 = strb_n;
            o0 = oe_n;
            sel(VECS[v].m3);
            chk("R2 mode at select", mode3_o, VECS[v].m3);
            xfer(VECS[v].op, rx);
            xfer(VECS[v].addr[23:16], rx);
            xfer(VECS[v].addr[15:8], rx);
            xfer(VECS[v].addr[7:0], rx);
            if (VECS[v].dmy) xfer(8'h00, rx);
            for (int k = 0; k < int'(VECS[v].nrd); k++) begin
                xfer(8'h00, rx);
                rx_mem[k] = rx;
            end
            chk("R6 R7 R13 one strobe per frame", strb_n - s0, 1);
            chk("R6 class", cap_cls, VECS[v].cls);
            chk(VECS[v].p264 ? "R4 page field" : "R5 page field", cap_page, VECS[v].pg);
            chk(VECS[v].p264 ? "R4 byte field" : "R5 byte field", cap_byte, VECS[v].by);
            epg = VECS[v].pg;
            eby = VECS[v].by;
            for (int k = 0; k < int'(VECS[v].nrd); k++) begin
                if (k == 0)
                    chk("R3 R8 first data byte", rx_mem[k], bdata(epg, eby));
                else if (VECS[v].cls == 3'd1)
                    chk("R9 array read stream", rx_mem[k], bdata(epg, eby));
                else
                    chk("R10 buffer read stream", rx_mem[k], bdata(epg, eby));
                advance(epg, eby, VECS[v].p264, VECS[v].cls == 3'd1);
            end
            if (VECS[v].nrd == 0)
                chk("R13 no output for erase or program", oe_n - o0, 0);
            else
                chk("R8 output enabled during read", (oe_n - o0) > 0, 1);
            desel(VECS[v].m3);
            chk("R11 output off after deselect", miso_oe_o, 0);
            chk("R2 mode held while idle", mode3_o, VECS[v].m3);
        end

        // Unknown opcode.
        std_page_i = 1'b1;
        s0 = strb_n;
        o0 = oe_n;
        sel(1'b0);
        xfer(8'h5A, rx); xfer(8'h12, rx); xfer(8'h34, rx); xfer(8'h56, rx); xfer(8'h00, rx);
        chk("R12 no output for unknown opcode", miso_oe_o, 0);
        desel(1'b0);
        chk("R12 no strobe for unknown opcode", strb_n - s0, 0);
        chk("R12 no output cycles for unknown opcode", oe_n - o0, 0);

        // Frame cut short during the address.
        s0 = strb_n;
        sel(1'b1);
        xfer(8'h0B, rx); xfer(8'h00, rx); xfer(8'h04, rx);
        desel(1'b1);
        chk("R11 aborted frame gives no strobe", strb_n - s0, 0);

        // Next frame decodes normally; read cut after one byte.
        sel(1'b1);
        xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h06, rx); xfer(8'h07, rx);
        xfer(8'h00, rx);
        chk("R11 frame after abort strobes", strb_n - s0, 1);
        chk("R11 frame after abort byte", cap_byte, 9'd7);
        chk("R11 frame after abort page", cap_page, 10'd3);
        chk("R11 data after abort", rx, bdata(10'd3, 9'd7));
        chk("R8 output on mid read", miso_oe_o, 1);
        cs_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 output off after mid read deselect", miso_oe_o, 0);
        repeat (4) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule